// File: doc/BRIEF.md
# Dual-Register Phase Accumulator

This block produces a 32-bit phase word for a downstream polar-to-rectangular stage used in waveform synthesis and in amplitude, frequency or phase modulation. Phase is scaled so that the full word range spans two pi. The most significant bit therefore weighs pi, and it may be read as either +pi or -pi, because the accumulator wraps modulo 2^32.

Two registers, a carrier and a modulation word, are written from one shared 32-bit input port under a 2-bit load code. A 2-bit mode input picks one of four behaviours. Bypass passes the upper half of the input word through. The other three modes accumulate: one with a phase offset from the modulation register, one with a frequency offset from it, and one as a plain tone. The accumulator feeds a registered output stage. A valid flag marks when that output stage holds a real accumulator result.

Top module: `phase_accum_dual`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the carrier, the modulation register, the accumulator and the output to zero, and drives `valid_o` low.
- R2: Load code 2'b00 leaves both the carrier and the modulation register unchanged.
- R3: Load code 2'b01 writes `phase_in` into the modulation register and leaves the carrier unchanged.
- R4: Load code 2'b10 writes `phase_in` into the carrier and leaves the modulation register unchanged.
- R5: Load code 2'b11 writes `phase_in` into the carrier and clears the modulation register to zero in the same edge.
- R6: In mode 2'b00 (bypass), the accumulator takes `phase_in[31:16]` in its upper half and zero in its lower half. `phase_in[15:0]` has no effect on the output.
- R7: In mode 2'b11 (tone), each edge adds the carrier value held before that edge to the accumulator.
- R8: In mode 2'b10 (frequency offset), each edge adds the sum of carrier and modulation to the accumulator.
- R9: In mode 2'b01 (phase offset), the accumulator advances by the carrier. The output is the accumulator plus the modulation register.
- R10: All sums are taken modulo 2^32. A carry out of bit 31 is dropped.
- R11: `phase_o` lags the accumulator by exactly one edge. The mode used for the output offset is the one present at that edge. `valid_o` goes high at the second edge after reset is released and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 2 | Carrier / modulation load code |
| mode_i | input | 2 | 00 bypass, 01 phase offset, 10 frequency offset, 11 tone |
| phase_in | input | 32 | Shared data input for the registers and for bypass |
| phase_o | output | 32 | Registered output phase word |
| valid_o | output | 1 | Output stage holds an accumulator result |

## Verification
The properties assume that `rst`, `load_i` and `mode_i` are known at every rising edge once the reset sequence starts. They also assume that load and mode codes are only ever interpreted one edge at a time, with no multi-cycle protocol. The stimulus keeps to this by changing every input on the falling edge only and by holding reset for two edges at the start.

Mode and load sweeps change codes freely from one edge to the next, including mode changes in the middle of an accumulation. This is legal because the block defines its result for each edge on its own. A mid-run reset exercises the clearing path a second time.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        LD_HOLD       = 2'b00,
        LD_MOD        = 2'b01,
        LD_CAR        = 2'b10,
        LD_CAR_CLRMOD = 2'b11
    } load_e;

    typedef enum logic [1:0] {
        MD_BYPASS = 2'b00,
        MD_PM     = 2'b01,
        MD_FM     = 2'b10,
        MD_CW     = 2'b11
    } mode_e;
endpackage

// File: rtl/pacc_loadctl.sv
module pacc_loadctl #(
    parameter int PW = 32
) (
    input  logic [1:0]    load_i,
    input  logic [PW-1:0] din_i,
    input  logic [PW-1:0] car_q_i,
    input  logic [PW-1:0] mod_q_i,
    output logic [PW-1:0] car_d_o,
    output logic [PW-1:0] mod_d_o
);
    import pacc_pkg::*;

    always_comb begin
        car_d_o = car_q_i;
        mod_d_o = mod_q_i;
        case (load_e'(load_i))
            LD_HOLD: ;
            LD_MOD:  mod_d_o = din_i;
            LD_CAR:  car_d_o = din_i;
            LD_CAR_CLRMOD: begin
                car_d_o = din_i;
                mod_d_o = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pacc_stepper.sv
module pacc_stepper #(
    parameter int PW = 32
) (
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] din_i,
    input  logic [PW-1:0] acc_q_i,
    input  logic [PW-1:0] car_q_i,
    input  logic [PW-1:0] mod_q_i,
    output logic [PW-1:0] acc_d_o,
    output logic [PW-1:0] out_d_o
);
    import pacc_pkg::*;

    localparam int HALF = PW / 2;
    localparam logic [PW-1:0] UPPER_MASK = {{(PW-HALF){1'b1}}, {HALF{1'b0}}};

    logic [PW-1:0] incr;

    always_comb begin
        incr    = car_q_i;
        acc_d_o = acc_q_i;
        out_d_o = acc_q_i;
        case (mode_e'(mode_i))
            MD_BYPASS: acc_d_o = din_i & UPPER_MASK;
            MD_PM: begin
                acc_d_o = acc_q_i + incr;
                out_d_o = acc_q_i + mod_q_i;
            end
            MD_FM: begin
                incr    = car_q_i + mod_q_i;
                acc_d_o = acc_q_i + incr;
            end
            MD_CW:   acc_d_o = acc_q_i + incr;
            default: ;
        endcase
    end
endmodule

// File: rtl/phase_accum_dual.sv
module phase_accum_dual #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    load_i,
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] phase_in,
    output logic [PW-1:0] phase_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [PW-1:0] car;
        logic [PW-1:0] modw;
        logic [PW-1:0] acc;
        logic [PW-1:0] out;
        logic          acc_vld;
        logic          out_vld;
    } state_t;

    state_t st_d, st_q;
    logic [PW-1:0] car_n, mod_n, acc_n, out_n;

    pacc_loadctl #(.PW(PW)) u_load (
        .load_i  (load_i),
        .din_i   (phase_in),
        .car_q_i (st_q.car),
        .mod_q_i (st_q.modw),
        .car_d_o (car_n),
        .mod_d_o (mod_n)
    );

    pacc_stepper #(.PW(PW)) u_step (
        .mode_i  (mode_i),
        .din_i   (phase_in),
        .acc_q_i (st_q.acc),
        .car_q_i (st_q.car),
        .mod_q_i (st_q.modw),
        .acc_d_o (acc_n),
        .out_d_o (out_n)
    );

    always_comb begin
        st_d         = st_q;
        st_d.car     = car_n;
        st_d.modw    = mod_n;
        st_d.acc     = acc_n;
        st_d.out     = out_n;
        st_d.acc_vld = 1'b1;
        st_d.out_vld = st_q.acc_vld;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o = st_q.out;
    assign valid_o = st_q.out_vld;
endmodule

// File: rtl/phase_accum_dual_chk.sv
module phase_accum_dual_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    load_i,
    input logic [1:0]    mode_i,
    input logic [PW-1:0] phase_in,
    input logic [PW-1:0] phase_o,
    input logic          valid_o,
    input logic [PW-1:0] car_q,
    input logic [PW-1:0] mod_q,
    input logic [PW-1:0] acc_q
);
    localparam int HALF = PW / 2;

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b1) begin
            assert_reset_clear_R1: assert (car_q == '0 && mod_q == '0 &&
                acc_q == '0 && phase_o == '0 && !valid_o)
                else $error("reset did not clear state");
        end
        rst_seen_q <= rst;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        load_i == 2'b00 |=> $stable(car_q) && $stable(mod_q));

    assert_modload_R3: assert property (@(posedge clk) disable iff (rst)
        load_i == 2'b01 |=> mod_q == $past(phase_in) && $stable(car_q));

    assert_carload_R4: assert property (@(posedge clk) disable iff (rst)
        load_i == 2'b10 |=> car_q == $past(phase_in) && $stable(mod_q));

    assert_carclr_R5: assert property (@(posedge clk) disable iff (rst)
        load_i == 2'b11 |=> mod_q == '0 && car_q == $past(phase_in));

    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b00 |=> acc_q[HALF-1:0] == '0 &&
            acc_q[PW-1:HALF] == $past(phase_in[PW-1:HALF]));

    assert_tone_step_R7: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b11 |=> acc_q == $past(acc_q) + $past(car_q));

    assert_fm_step_R8: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b10 |=> acc_q == $past(acc_q) + $past(car_q) + $past(mod_q));

    assert_pm_out_R9: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b01 |=> phase_o == $past(acc_q) + $past(mod_q));

    assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);
endmodule

bind phase_accum_dual phase_accum_dual_chk #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .mode_i   (mode_i),
    .phase_in (phase_in),
    .phase_o  (phase_o),
    .valid_o  (valid_o),
    .car_q    (st_q.car),
    .mod_q    (st_q.modw),
    .acc_q    (st_q.acc)
);

// File: tb/sim_phase_accum_dual.sv
module sim_phase_accum_dual;
    localparam int  PW     = 32;
    localparam time PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    load_i;
    logic [1:0]    mode_i;
    logic [PW-1:0] phase_in;
    logic [PW-1:0] phase_o;
    logic          valid_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [PW-1:0] m_car, m_mod, m_acc, m_out;
    logic          m_av, m_v;
    string         last_tag;

    always #(PERIOD/2) clk = ~clk;

    phase_accum_dual #(.PW(PW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .mode_i   (mode_i),
        .phase_in (phase_in),
        .phase_o  (phase_o),
        .valid_o  (valid_o)
    );

    function automatic string tag_for_load(input int l);
        case (l)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic compare();
        n_vec++;
        if (phase_o !== m_out || valid_o !== m_v) begin
            n_fail++;
            $display("FAIL %s: phase_o=%08h valid_o=%0b expected phase_o=%08h valid_o=%0b",
                     last_tag, phase_o, valid_o, m_out, m_v);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] ld, input logic [1:0] md,
                        input logic [PW-1:0] d, input string tag);
        logic [PW-1:0] nc, nm, na, no;
        @(negedge clk);
        compare();
        rst = r; load_i = ld; mode_i = md; phase_in = d;
        @(posedge clk);
        nc = ld[1] ? d : m_car;
        nm = (ld == 2'b01) ? d : (ld == 2'b11) ? '0 : m_mod;
        no = m_acc + ((md == 2'b01) ? m_mod : '0);
        case (md)
            2'b00:   na = {d[PW-1:PW/2], {(PW/2){1'b0}}};
            2'b10:   na = m_acc + m_car + m_mod;
            default: na = m_acc + m_car;
        endcase
        if (r) begin
            m_car = '0; m_mod = '0; m_acc = '0; m_out = '0; m_av = 1'b0; m_v = 1'b0;
        end else begin
            m_car = nc; m_mod = nm; m_acc = na; m_out = no; m_v = m_av; m_av = 1'b1;
        end
        last_tag = tag;
    endtask

    initial begin
        rst = 1'b1; load_i = 2'b00; mode_i = 2'b00; phase_in = '0;
        m_car = '0; m_mod = '0; m_acc = '0; m_out = '0; m_av = 1'b0; m_v = 1'b0;
        last_tag = "R1";
        step(1'b1, 2'b11, 2'b10, 32'hDEAD_BEEF, "R1");
        step(1'b1, 2'b01, 2'b01, 32'h1234_5678, "R1");
        // first release: valid timing
        step(1'b0, 2'b00, 2'b11, 32'h0, "R11");
        step(1'b0, 2'b00, 2'b11, 32'h0, "R11");
        // load modulation, then carrier, tone accumulation
        step(1'b0, 2'b01, 2'b11, 32'h1234_5678, "R3");
        step(1'b0, 2'b10, 2'b11, 32'h0100_0000, "R4");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b11, 32'hFFFF_0000 ^ i, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 2'b11, 32'h5A5A_5A5A + i, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b01, 32'h0, "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b10, 32'h0, "R8");
        step(1'b0, 2'b11, 2'b10, 32'h0080_0000, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 2'b10, 32'h0, "R5");
        // bypass: lower bits vary and must not show up
        for (int i = 0; i < 32; i++) step(1'b0, 2'b00, 2'b00, 32'(i) * 32'h9E37_79B9, "R6");
        // wrap past 2^32
        step(1'b0, 2'b10, 2'b11, 32'hC000_0001, "R10");
        for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 2'b11, 32'h0, "R10");
        step(1'b0, 2'b01, 2'b01, 32'hF000_0000, "R10");
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 2'b10, 32'h0, "R10");
        // sweep all modes and load codes
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 4; l++)
                for (int k = 0; k < 4; k++)
                    step(1'b0, 2'(l), 2'(m), 32'(m * 1000 + l * 77 + k) * 32'h6C07_8965,
                         tag_for_load(l));
        // mode change mid-run: output offset follows current mode
        for (int i = 0; i < 8; i++) step(1'b0, 2'b00, 2'(i % 4), 32'h0, "R11");
        // mid-run reset
        step(1'b1, 2'b10, 2'b11, 32'h7777_7777, "R1");
        step(1'b0, 2'b00, 2'b11, 32'h0, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 2'b10, 2'b11, 32'h0000_1000, "R11");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule